// File: doc/BRIEF.md
# Barrier Reduction Accumulator

This block keeps one reduction word for every pairing of a thread group (cooperative thread array slot) and a barrier number. When a warp arrives at a barrier of the reducing kind, it sends one accumulate request. The request carries the group slot, the barrier number, the reduction operation, the lane active mask and one predicate bit per lane. Each active lane contributes the inverse of its predicate bit. The block folds the contributions of all lanes into the addressed word in a single request, by adding their population count or by combining them with AND or OR.

When the surrounding barrier logic decides that a barrier has released, it issues one release request per released warp. The request carries that warp's active lane mask. The block returns the 32-bit word together with the mask, so that the writeback path can deliver the value to exactly those lanes. The last release request of a barrier sets a flag, and that flag returns the entry to its empty state so that the barrier can be used again. This block does not decide when a barrier releases, and it does not write registers.

Storage is a synchronous-read array that block RAM can hold. A small vector of per-entry occupancy flags is reset as a whole, and this lets every entry read as zero after reset without clearing the array.

Top module: `bar_reduce_accum`

## Requirements
- R1: After a synchronous reset, res_vld and op_err are low, and a release of any entry that has received no accumulate since reset returns res_value 0.
- R2: Lane i contributes the bit ~acc_pred[i], and only when acc_mask[i] is 1. Predicate bits of inactive lanes have no effect on the stored word.
- R3: Operation code 2'd0 (population count) adds the number of contributing ones to the entry's word, and the sum builds up across successive requests to the same entry.
- R4: Operation code 2'd1 (AND) ANDs the zero-extended AND of all contributing bits into the word. The first accumulate into an empty entry stores that AND directly, so an empty active mask stores 1.
- R5: Operation code 2'd2 (OR) ORs the zero-extended OR of all contributing bits into the word. An empty entry starts from 0.
- R6: A release request sampled at clock edge k drives res_vld high for exactly one cycle after edge k+1. In that cycle res_mask equals the request's rel_mask and res_value equals the entry's word.
- R7: Entries are addressed by {cta, barrier}, and an accumulate or a clear to one entry leaves every other entry unchanged.
- R8: A release sampled in the same cycle as an accumulate to the same entry returns the word before that accumulate. Accumulates and releases in consecutive cycles observe every earlier accumulate.
- R9: A release with rel_last set empties its entry after it has been read, so a later release reads 0. An accumulate to that entry in the same cycle starts the next round from empty.
- R10: Operation code 2'd3 raises op_err for one cycle after the second clock edge and leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Accumulate request valid |
| acc_cta | input | CTA_W (5) | Group slot of the accumulate |
| acc_bar | input | BAR_W (4) | Barrier number of the accumulate |
| acc_op | input | 2 | Operation: 0 popcount, 1 AND, 2 OR, 3 illegal |
| acc_mask | input | LANES (32) | Active lanes of the arriving warp |
| acc_pred | input | LANES (32) | Per-lane predicate bit |
| rel_vld | input | 1 | Release request valid |
| rel_cta | input | CTA_W (5) | Group slot of the release |
| rel_bar | input | BAR_W (4) | Barrier number of the release |
| rel_mask | input | LANES (32) | Active lanes of the released warp |
| rel_last | input | 1 | Final release of this barrier; empty the entry |
| res_vld | output | 1 | Result valid |
| res_mask | output | LANES (32) | Lanes that receive the result |
| res_value | output | WORD_W (32) | Reduction result |
| op_err | output | 1 | Illegal operation code seen |

## Verification
The bench concentrates on entry hazards. It sends back-to-back accumulates to one entry, which a design without write forwarding would lose. It reads and accumulates one entry in the same cycle, where a design that reads after the update would return a post-update value. It clears an entry while accumulating into it, where a wrong design would either drop the new contribution or keep the old round. Further cases cover an AND into an empty entry (stored 0 if the identity is missing), inactive lanes carrying predicate bits that must not count, an illegal operation code that must neither flag late nor alter storage, and the highest group slot and barrier number, to catch index aliasing.

// File: rtl/bar_reduce_pkg.sv
package bar_reduce_pkg;

  typedef enum logic [1:0] {
    RED_POPC = 2'd0,
    RED_AND  = 2'd1,
    RED_OR   = 2'd2,
    RED_BAD  = 2'd3
  } red_op_e;

  function automatic logic op_legal(input logic [1:0] op);
    return (op == RED_POPC) || (op == RED_AND) || (op == RED_OR);
  endfunction

endpackage

// File: rtl/brd_lane_reduce.sv
module brd_lane_reduce #(
  parameter int LANES = 32,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] pred,
  output logic [CNT_W-1:0] ones,
  output logic             all_bit,
  output logic             any_bit
);

  logic [LANES-1:0] contrib;

  // Active lanes contribute the inverse of their predicate.
  assign contrib = ~pred & mask;

  always_comb begin
    ones = '0;
    for (int i = 0; i < LANES; i++) begin
      ones = ones + CNT_W'(contrib[i]);
    end
  end

  assign all_bit = &(contrib | ~mask);
  assign any_bit = |contrib;

endmodule

// File: rtl/brd_combine.sv
module brd_combine
  import bar_reduce_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [1:0]        op,
  input  logic              fresh,
  input  logic [WORD_W-1:0] base,
  input  logic [CNT_W-1:0]  ones,
  input  logic              all_bit,
  input  logic              any_bit,
  output logic [WORD_W-1:0] result
);

  logic [WORD_W-1:0] start;

  always_comb begin
    // Identity seeding for an empty entry.
    if (fresh) begin
      start = (op == RED_AND) ? {WORD_W{1'b1}} : '0;
    end else begin
      start = base;
    end
    case (op)
      RED_POPC: result = start + WORD_W'(ones);
      RED_AND:  result = start & WORD_W'(all_bit);
      RED_OR:   result = start | WORD_W'(any_bit);
      default:  result = start;
    endcase
  end

endmodule

// File: rtl/brd_store.sv
module brd_store #(
  parameter int DEPTH  = 512,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_a_en,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic [IDX_W-1:0]  chk_a_idx,
  output logic              used_a,
  input  logic [IDX_W-1:0]  chk_b_idx,
  output logic              used_b,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  used_q;

  // Array without reset: synchronous read, old data on collision.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
    if (rd_a_en) begin
      rd_a_data <= mem[rd_a_idx];
    end
    if (rd_b_en) begin
      rd_b_data <= mem[rd_b_idx];
    end
  end

  // Occupancy flags: a clear loses to a write of the same entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else begin
      if (clr_en && !(wr_en && (wr_idx == clr_idx))) begin
        used_q[clr_idx] <= 1'b0;
      end
      if (wr_en) begin
        used_q[wr_idx] <= 1'b1;
      end
    end
  end

  assign used_a = used_q[chk_a_idx];
  assign used_b = used_q[chk_b_idx];

endmodule

// File: rtl/bar_reduce_accum.sv
module bar_reduce_accum
  import bar_reduce_pkg::*;
#(
  parameter int CTA_NUM = 32,
  parameter int BAR_NUM = 16,
  parameter int LANES   = 32,
  parameter int WORD_W  = 32,
  localparam int CTA_W  = $clog2(CTA_NUM),
  localparam int BAR_W  = $clog2(BAR_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic [CTA_W-1:0]  acc_cta,
  input  logic [BAR_W-1:0]  acc_bar,
  input  logic [1:0]        acc_op,
  input  logic [LANES-1:0]  acc_mask,
  input  logic [LANES-1:0]  acc_pred,
  input  logic              rel_vld,
  input  logic [CTA_W-1:0]  rel_cta,
  input  logic [BAR_W-1:0]  rel_bar,
  input  logic [LANES-1:0]  rel_mask,
  input  logic              rel_last,
  output logic              res_vld,
  output logic [LANES-1:0]  res_mask,
  output logic [WORD_W-1:0] res_value,
  output logic              op_err
);

  localparam int IDX_W = CTA_W + BAR_W;
  localparam int DEPTH = CTA_NUM * BAR_NUM;
  localparam int CNT_W = $clog2(LANES + 1);

  logic [IDX_W-1:0] acc_idx, rel_idx;
  assign acc_idx = {acc_cta, acc_bar};
  assign rel_idx = {rel_cta, rel_bar};

  // Lane reduction overlaps the array read.
  logic [CNT_W-1:0] lr_ones;
  logic             lr_all, lr_any;

  brd_lane_reduce #(.LANES(LANES), .CNT_W(CNT_W)) u_lane (
    .mask    (acc_mask),
    .pred    (acc_pred),
    .ones    (lr_ones),
    .all_bit (lr_all),
    .any_bit (lr_any)
  );

  // Stage A registers
  logic             sa_acc_vld, sa_rel_vld, sa_rel_last;
  logic [IDX_W-1:0] sa_acc_idx, sa_rel_idx;
  logic [1:0]       sa_op;
  logic [CNT_W-1:0] sa_ones;
  logic             sa_all, sa_any;
  logic [LANES-1:0] sa_rel_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_acc_vld  <= 1'b0;
      sa_rel_vld  <= 1'b0;
      sa_rel_last <= 1'b0;
    end else begin
      sa_acc_vld  <= acc_vld;
      sa_rel_vld  <= rel_vld;
      sa_rel_last <= rel_vld && rel_last;
    end
  end

  always_ff @(posedge clk) begin
    sa_acc_idx  <= acc_idx;
    sa_rel_idx  <= rel_idx;
    sa_op       <= acc_op;
    sa_ones     <= lr_ones;
    sa_all      <= lr_all;
    sa_any      <= lr_any;
    sa_rel_mask <= rel_mask;
  end

  // Storage
  logic [WORD_W-1:0] rd_a, rd_b, new_word;
  logic              used_a, used_b, wr_en, clr_en;

  brd_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd_a_en   (acc_vld),
    .rd_a_idx  (acc_idx),
    .rd_a_data (rd_a),
    .rd_b_en   (rel_vld),
    .rd_b_idx  (rel_idx),
    .rd_b_data (rd_b),
    .chk_a_idx (sa_acc_idx),
    .used_a    (used_a),
    .chk_b_idx (sa_rel_idx),
    .used_b    (used_b),
    .wr_en     (wr_en),
    .wr_idx    (sa_acc_idx),
    .wr_data   (new_word),
    .clr_en    (clr_en),
    .clr_idx   (sa_rel_idx)
  );

  // Forwarding of the write that landed while the array was being read.
  logic              lw_vld;
  logic [IDX_W-1:0]  lw_idx;
  logic [WORD_W-1:0] lw_data;
  logic [WORD_W-1:0] acc_cur, rel_cur;
  logic              acc_fresh, legal;

  always_comb begin
    acc_cur = '0;
    if (used_a) begin
      acc_cur = (lw_vld && (lw_idx == sa_acc_idx)) ? lw_data : rd_a;
    end
    rel_cur = '0;
    if (used_b) begin
      rel_cur = (lw_vld && (lw_idx == sa_rel_idx)) ? lw_data : rd_b;
    end
  end

  assign legal     = op_legal(sa_op);
  assign clr_en    = sa_rel_vld && sa_rel_last;
  assign acc_fresh = !used_a || (clr_en && (sa_rel_idx == sa_acc_idx));
  assign wr_en     = sa_acc_vld && legal;

  brd_combine #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_comb (
    .op      (sa_op),
    .fresh   (acc_fresh),
    .base    (acc_cur),
    .ones    (sa_ones),
    .all_bit (sa_all),
    .any_bit (sa_any),
    .result  (new_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_vld <= 1'b0;
    end else begin
      lw_vld <= wr_en;
    end
    lw_idx  <= sa_acc_idx;
    lw_data <= new_word;
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_mask  <= '0;
      res_value <= '0;
      op_err    <= 1'b0;
    end else begin
      res_vld   <= sa_rel_vld;
      res_mask  <= sa_rel_vld ? sa_rel_mask : '0;
      res_value <= sa_rel_vld ? rel_cur : '0;
      op_err    <= sa_acc_vld && !legal;
    end
  end

endmodule

module bar_reduce_accum_chk #(
  parameter int CTA_W  = 5,
  parameter int BAR_W  = 4,
  parameter int LANES  = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_vld,
  input logic [CTA_W-1:0]  acc_cta,
  input logic [BAR_W-1:0]  acc_bar,
  input logic [1:0]        acc_op,
  input logic              rel_vld,
  input logic [CTA_W-1:0]  rel_cta,
  input logic [BAR_W-1:0]  rel_bar,
  input logic [LANES-1:0]  rel_mask,
  input logic              rel_last,
  input logic              res_vld,
  input logic [LANES-1:0]  res_mask,
  input logic [WORD_W-1:0] res_value,
  input logic              op_err
);

  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!res_vld && !op_err));

  p_res_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(rel_vld, 2));

  p_rel_answered_r6: assert property (@(posedge clk) disable iff (rst)
    rel_vld |-> ##2 res_vld);

  p_mask_carried_r6: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (res_mask == $past(rel_mask, 2)));

  p_err_source_r10: assert property (@(posedge clk) disable iff (rst)
    op_err |-> ($past(acc_vld, 2) && ($past(acc_op, 2) == 2'd3)));

  p_clear_then_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rel_vld && !acc_vld && $past(rel_vld && rel_last && !acc_vld) &&
     (rel_cta == $past(rel_cta)) && (rel_bar == $past(rel_bar)))
    |-> ##2 (res_value == '0));

endmodule

bind bar_reduce_accum bar_reduce_accum_chk #(
  .CTA_W(CTA_W), .BAR_W(BAR_W), .LANES(LANES), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_cta(acc_cta),
  .acc_bar(acc_bar), .acc_op(acc_op), .rel_vld(rel_vld),
  .rel_cta(rel_cta), .rel_bar(rel_bar), .rel_mask(rel_mask),
  .rel_last(rel_last), .res_vld(res_vld), .res_mask(res_mask),
  .res_value(res_value), .op_err(op_err)
);

// File: tb/bar_reduce_accum_bench.sv
`timescale 1ns/1ps
module bar_reduce_accum_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0;
  logic [4:0]  acc_cta = '0;
  logic [3:0]  acc_bar = '0;
  logic [1:0]  acc_op = '0;
  logic [31:0] acc_mask = '0;
  logic [31:0] acc_pred = '0;
  logic        rel_vld = 1'b0;
  logic [4:0]  rel_cta = '0;
  logic [3:0]  rel_bar = '0;
  logic [31:0] rel_mask = '0;
  logic        rel_last = 1'b0;
  logic        res_vld;
  logic [31:0] res_mask;
  logic [31:0] res_value;
  logic        op_err;

  always #2.5 clk = ~clk;

  bar_reduce_accum u_bar_reduce_accum (
    .clk(clk), .rst(rst),
    .acc_vld(acc_vld), .acc_cta(acc_cta), .acc_bar(acc_bar), .acc_op(acc_op),
    .acc_mask(acc_mask), .acc_pred(acc_pred),
    .rel_vld(rel_vld), .rel_cta(rel_cta), .rel_bar(rel_bar),
    .rel_mask(rel_mask), .rel_last(rel_last),
    .res_vld(res_vld), .res_mask(res_mask), .res_value(res_value),
    .op_err(op_err)
  );

  // Reference model state
  int unsigned mval [512];
  bit          mused [512];
  int          vectors = 0;
  int          fails = 0;
  bit          done = 1'b0;

  // Expectation for the request in flight (one step behind)
  bit          e_v = 0, e_err = 0;
  int unsigned e_val = 0;
  logic [31:0] e_mask = '0;
  string       e_tag = "R1";

  task automatic compare();
    vectors++;
    if (res_vld !== e_v || op_err !== e_err ||
        (e_v && (res_value !== e_val || res_mask !== e_mask))) begin
      fails++;
      $display("FAIL %s: vld=%0b val=%0d mask=%h err=%0b expected vld=%0b val=%0d mask=%h err=%0b",
               e_tag, res_vld, res_value, res_mask, op_err, e_v, e_val, e_mask, e_err);
    end
  endtask

  task automatic step(input string tag,
                      input bit av, input int ac, input int ab, input logic [1:0] aop,
                      input logic [31:0] am, input logic [31:0] ap,
                      input bit rv, input int rc, input int rb,
                      input logic [31:0] rm, input bit rl);
    bit          n_v, n_err;
    int unsigned n_val, base, cnt;
    bit          all_b, any_b;
    int          ai, ri;
    acc_vld = av; acc_cta = ac[4:0]; acc_bar = ab[3:0]; acc_op = aop;
    acc_mask = am; acc_pred = ap;
    rel_vld = rv; rel_cta = rc[4:0]; rel_bar = rb[3:0]; rel_mask = rm; rel_last = rl;
    ai = ac * 16 + ab;
    ri = rc * 16 + rb;
    n_v = rv;
    n_val = (rv && mused[ri]) ? mval[ri] : 0;
    n_err = av && (aop == 2'd3);
    if (rv && rl) mused[ri] = 0;
    if (av && aop != 2'd3) begin
      cnt = 0; all_b = 1; any_b = 0;
      for (int i = 0; i < 32; i++) begin
        if (am[i]) begin
          cnt += (ap[i] ? 0 : 1);
          all_b &= ~ap[i];
          any_b |= ~ap[i];
        end
      end
      if (mused[ai]) base = mval[ai];
      else base = (aop == 2'd1) ? 32'hFFFF_FFFF : 0;
      case (aop)
        2'd0: mval[ai] = base + cnt;
        2'd1: mval[ai] = base & {31'b0, all_b};
        default: mval[ai] = base | {31'b0, any_b};
      endcase
      mused[ai] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    e_v = n_v; e_val = n_val; e_mask = rv ? rm : '0; e_err = n_err; e_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 2'd0, '0, '0, 0, 0, 0, '0, 0);
  endtask

  task automatic acc(input string tag, input int c, input int b, input logic [1:0] op,
                     input logic [31:0] m, input logic [31:0] p);
    step(tag, 1, c, b, op, m, p, 0, 0, 0, '0, 0);
  endtask

  task automatic rel(input string tag, input int c, input int b,
                     input logic [31:0] m, input bit last);
    step(tag, 0, 0, 0, 2'd0, '0, '0, 1, c, b, m, last);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin mval[i] = 0; mused[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state and empty entries
    idle("R1");
    rel("R1", 3, 5, 32'h0000_00FF, 0);
    idle("R1");
    // R3 / R2: popcount with inactive-lane predicates ignored
    acc("R3", 1, 2, 2'd0, 32'hFFFF_FFFF, 32'h0000_00FF);
    acc("R2", 1, 2, 2'd0, 32'h0000_FFFF, 32'hFFFF_0F0F);
    idle("R3");
    rel("R3", 1, 2, 32'hFFFF_FFFF, 0);
    rel("R6", 1, 2, 32'h0000_0F0F, 1);
    idle("R6");
    // R9: cleared entry reads zero
    rel("R9", 1, 2, 32'h1, 0);
    idle("R9");
    // R4: AND seeding and combining
    acc("R4", 2, 0, 2'd1, 32'h0000_000F, 32'hFFFF_FFF0);
    idle("R4");
    rel("R4", 2, 0, 32'hF, 0);
    acc("R4", 2, 0, 2'd1, 32'h0000_00FF, 32'h0000_00F0);
    idle("R4");
    rel("R4", 2, 0, 32'hFF, 1);
    acc("R4", 2, 1, 2'd1, 32'h0, 32'hFFFF_FFFF);
    idle("R4");
    rel("R4", 2, 1, 32'h3, 1);
    // R5 / R7: OR at highest ids, neighbours untouched
    acc("R5", 31, 15, 2'd2, 32'h0000_0001, 32'h0000_0001);
    idle("R5");
    rel("R5", 31, 15, 32'h1, 0);
    acc("R5", 31, 15, 2'd2, 32'h8000_0000, 32'h0);
    idle("R5");
    rel("R5", 31, 15, 32'h8000_0000, 1);
    acc("R7", 4, 1, 2'd0, 32'h0000_0007, 32'h0);
    acc("R7", 4, 2, 2'd0, 32'h0000_001F, 32'h0);
    acc("R7", 5, 1, 2'd0, 32'h0000_0001, 32'h0);
    rel("R7", 4, 1, 32'h7, 0);
    rel("R7", 4, 2, 32'h1F, 0);
    rel("R7", 5, 1, 32'h1, 0);
    rel("R7", 31, 14, 32'h1, 0);
    // R8: back-to-back accumulates, then same-cycle read and accumulate
    acc("R8", 6, 3, 2'd0, 32'h0000_0003, 32'h0);
    acc("R8", 6, 3, 2'd0, 32'h0000_000C, 32'h0);
    acc("R8", 6, 3, 2'd0, 32'h0000_0030, 32'h0);
    rel("R8", 6, 3, 32'hFFFF, 0);
    step("R8", 1, 6, 3, 2'd0, 32'h0000_00FF, 32'h0, 1, 6, 3, 32'hAAAA, 0);
    rel("R8", 6, 3, 32'h5555, 0);
    // R9: clear and accumulate together start a new round
    step("R9", 1, 6, 3, 2'd0, 32'h0000_0001, 32'h0, 1, 6, 3, 32'h1, 1);
    rel("R9", 6, 3, 32'h2, 0);
    rel("R9", 6, 3, 32'h4, 1);
    rel("R9", 6, 3, 32'h8, 0);
    // R10: illegal operation flags and changes nothing
    acc("R10", 7, 7, 2'd0, 32'h0000_000F, 32'h0);
    acc("R10", 7, 7, 2'd3, 32'hFFFF_FFFF, 32'h0);
    idle("R10");
    rel("R10", 7, 7, 32'hF, 0);
    acc("R10", 7, 8, 2'd3, 32'hFFFF_FFFF, 32'h0);
    rel("R10", 7, 8, 32'h1, 0);
    idle("R10");
    idle("R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog: done=0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule